// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a 16-bit up-counting interval timer that sits on a small byte-wide register bus. A fixed prescaler divides the system clock by twelve. While the run bit is set, the count advances by one on each prescaler tick. When the count passes from all ones to zero, it does not land on zero. It takes the 16-bit value held in two reload byte registers instead, and a sticky overflow flag is raised. Software sets the interval by choosing the reload value.

An optional low-byte mode raises a second, separate sticky flag each time the low count byte rolls from 0xFF to 0x00. This gives a finer periodic interrupt. The two flags and their enables combine into one interrupt request. A borrow input lets a serial-bus clock-low timeout function claim the timer. While the borrow is high, software cannot change the count or reload values and the interrupt request is held low.

Top module: `reload_timer16`

## Requirements
- R1: After reset the count and reload registers are 0x0000. The control byte reads 0x01: run set, interrupt enable, low-byte mode and both flags clear.
- R2: While run is 1, the count increases by one on every 12th clock edge. While run is 0 the prescaler is held at zero. After run is written to 1 at edge E, the first increment lands on edge E+12.
- R3: A tick that finds the count at 0xFFFF loads the reload value into the count and sets the overflow flag (control bit 7).
- R4: With low-byte mode (control bit 2) set, a tick that finds the low count byte at 0xFF sets the low-wrap flag (control bit 6). With the mode clear, that flag is not set.
- R5: Both flags stay set until a control write carries 0 in that flag's bit position. Writing 1 there leaves the flag unchanged. A set event in the same cycle as a clearing write leaves the flag set.
- R6: irq equals interrupt enable (control bit 1) AND (overflow flag OR (low-wrap flag AND low-byte mode)) AND NOT timeout_borrow. It follows flag changes in the same cycle they become visible.
- R7: A write to a count byte takes effect on that edge and replaces any increment in that cycle. No flag is set by a tick that is replaced this way.
- R8: While timeout_borrow is 1, writes to count and reload bytes are ignored and irq is held low. Control writes still apply.
- R9: Register map on bus_addr: 0 count low byte, 1 count high byte, 2 reload low byte, 3 reload high byte, 4 control. Control bit 0 is run. Addresses 5 to 7 read 0x00 and writes to them have no effect. Reads are combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_wr | input | 1 | Write strobe, applied on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| timeout_borrow | input | 1 | Timer claimed by the bus timeout function |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and count increments appear on bus_rdata right after the edge that takes them. Flags therefore reach irq in that cycle as well. The first increment after run is set is due exactly twelve edges later. The borrow gate on irq acts with no delay. The bench applies inputs after a falling edge and lets one rising edge act. It then compares read data and irq at the next falling edge against a cycle model kept in the bench. The directed cases count edges from the enabling write, so the sample lands one edge before and on the edge where a tick is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_RUN    = 0;
    localparam int BIT_IEN    = 1;
    localparam int BIT_LMODE  = 2;
    localparam int BIT_LFLAG  = 6;
    localparam int BIT_OFLAG  = 7;

    typedef struct packed {
        logic lmode;
        logic ien;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic lwrap;
    } flags_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RELOAD,
        SEL_CTRL
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input int unsigned a, input int unsigned nbytes);
        reg_sel_t s;
        s.kind = SEL_NONE;
        s.idx  = '0;
        if (a < nbytes) begin
            s.kind = SEL_COUNT;
            s.idx  = 4'(a);
        end else if (a < 2 * nbytes) begin
            s.kind = SEL_RELOAD;
            s.idx  = 4'(a - nbytes);
        end else if (a == 2 * nbytes) begin
            s.kind = SEL_CTRL;
        end
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c, input flags_t f);
        logic [BYTE_W-1:0] v;
        v            = '0;
        v[BIT_RUN]   = c.run;
        v[BIT_IEN]   = c.ien;
        v[BIT_LMODE] = c.lmode;
        v[BIT_LFLAG] = f.lwrap;
        v[BIT_OFLAG] = f.ovf;
        return v;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 12,
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic          tick,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] TERM = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (phase_q == TERM) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick  = run && (phase_q == TERM);
    assign phase = phase_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NB-1:0]     cnt_we,
    input  logic [NB-1:0]     rld_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  rld,
    output logic              ovf_evt,
    output logic              lwrap_evt
);
    logic [CNT_W-1:0] cnt_q, cnt_d, rld_q;
    logic             sw_write, step;

    assign sw_write = |cnt_we;
    assign step     = tick && !sw_write;

    for (genvar b = 0; b < NB; b++) begin : g_rld
        always_ff @(posedge clk) begin
            if (rst) begin
                rld_q[b*BYTE_W +: BYTE_W] <= '0;
            end else if (rld_we[b]) begin
                rld_q[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (sw_write) begin
            for (int b = 0; b < NB; b++) begin
                if (cnt_we[b]) cnt_d[b*BYTE_W +: BYTE_W] = wdata;
            end
        end else if (tick) begin
            cnt_d = (cnt_q == '1) ? rld_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign ovf_evt   = step && (cnt_q == '1);
    assign lwrap_evt = step && (cnt_q[BYTE_W-1:0] == '1);
    assign cnt       = cnt_q;
    assign rld       = rld_q;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ovf_evt,
    input  logic              lwrap_evt,
    input  logic              borrow,
    output ctrl_t             ctrl,
    output flags_t            flags,
    output logic              irq
);
    ctrl_t  ctrl_q;
    flags_t flags_q;
    logic   lwrap_set;

    assign lwrap_set = lwrap_evt && ctrl_q.lmode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{lmode: 1'b0, ien: 1'b0, run: 1'b1};
        end else if (ctrl_we) begin
            ctrl_q.run   <= wdata[BIT_RUN];
            ctrl_q.ien   <= wdata[BIT_IEN];
            ctrl_q.lmode <= wdata[BIT_LMODE];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            if (ovf_evt)                             flags_q.ovf <= 1'b1;
            else if (ctrl_we && !wdata[BIT_OFLAG])   flags_q.ovf <= 1'b0;
            if (lwrap_set)                           flags_q.lwrap <= 1'b1;
            else if (ctrl_we && !wdata[BIT_LFLAG])   flags_q.lwrap <= 1'b0;
        end
    end

    assign irq   = ctrl_q.ien && !borrow &&
                   (flags_q.ovf || (flags_q.lwrap && ctrl_q.lmode));
    assign ctrl  = ctrl_q;
    assign flags = flags_q;
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV    = 12,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              timeout_borrow,
    output logic              irq
);
    localparam int NB = CNT_W / BYTE_W;
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    reg_sel_t         sel;
    logic [NB-1:0]    cnt_we, rld_we;
    logic             ctrl_we, tick, ovf_evt, lwrap_evt;
    logic [PW-1:0]    phase;
    logic [CNT_W-1:0] cnt, rld;
    ctrl_t            ctrl;
    flags_t           flags;

    assign sel     = decode_addr(32'(bus_addr), NB);
    assign ctrl_we = bus_wr && (sel.kind == SEL_CTRL);

    for (genvar b = 0; b < NB; b++) begin : g_we
        assign cnt_we[b] = bus_wr && !timeout_borrow &&
                           (sel.kind == SEL_COUNT) && (sel.idx == 4'(b));
        assign rld_we[b] = bus_wr && !timeout_borrow &&
                           (sel.kind == SEL_RELOAD) && (sel.idx == 4'(b));
    end

    tmr_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run),
        .tick  (tick),
        .phase (phase)
    );

    tmr_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_we    (cnt_we),
        .rld_we    (rld_we),
        .wdata     (bus_wdata),
        .cnt       (cnt),
        .rld       (rld),
        .ovf_evt   (ovf_evt),
        .lwrap_evt (lwrap_evt)
    );

    tmr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .wdata     (bus_wdata),
        .ovf_evt   (ovf_evt),
        .lwrap_evt (lwrap_evt),
        .borrow    (timeout_borrow),
        .ctrl      (ctrl),
        .flags     (flags),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            SEL_COUNT: begin
                for (int b = 0; b < NB; b++)
                    if (sel.idx == 4'(b)) bus_rdata = cnt[b*BYTE_W +: BYTE_W];
            end
            SEL_RELOAD: begin
                for (int b = 0; b < NB; b++)
                    if (sel.idx == 4'(b)) bus_rdata = rld[b*BYTE_W +: BYTE_W];
            end
            SEL_CTRL: bus_rdata = pack_ctrl(ctrl, flags);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int PW     = 4,
    parameter int NB     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              timeout_borrow,
    input logic              irq,
    input logic              tick,
    input logic              run,
    input logic [PW-1:0]     phase,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  rld,
    input logic [NB-1:0]     cnt_we,
    input logic              ovf_evt,
    input logic              ovf_flag,
    input logic              ctrl_we
);
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0));

    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt_we == '0) && (cnt == '1)) |=> (cnt == $past(rld)));

    a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ctrl_we) |=> ovf_flag);

    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !timeout_borrow && (bus_addr == '0)) |=> (cnt[7:0] == $past(bus_wdata)));

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        timeout_borrow |-> !irq);

    a_r8_reload_locked: assert property (@(posedge clk) disable iff (rst)
        timeout_borrow |=> $stable(rld));
endmodule

bind reload_timer16 tmr_checker #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PW(PW), .NB(NB)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .timeout_borrow (timeout_borrow),
    .irq            (irq),
    .tick           (tick),
    .run            (ctrl.run),
    .phase          (phase),
    .cnt            (cnt),
    .rld            (rld),
    .cnt_we         (cnt_we),
    .ovf_evt        (ovf_evt),
    .ovf_flag       (flags.ovf),
    .ctrl_we        (ctrl_we)
);

// File: tb/reload_timer16_tb.sv
module reload_timer16_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] b_addr = '0;
    logic       b_wr = 1'b0;
    logic [7:0] b_wdata = '0;
    logic       b_borrow = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_cnt, m_rld;
    logic        m_run, m_ien, m_lm, m_of, m_lf;
    int          m_pc;

    always #(CLK_P/2) clk = ~clk;

    reload_timer16 u_dut (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr(b_wr),
        .bus_wdata(b_wdata), .bus_rdata(rdata),
        .timeout_borrow(b_borrow), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt[7:0];
            3'd1: return m_cnt[15:8];
            3'd2: return m_rld[7:0];
            3'd3: return m_rld[15:8];
            3'd4: return {m_of, m_lf, 3'b000, m_lm, m_ien, m_run};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_ien && !b_borrow && (m_of || (m_lf && m_lm));
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic tk, cw, rw, ctw, ov, lw;
        if (rst) begin
            m_cnt = '0; m_rld = '0; m_run = 1'b1; m_ien = 1'b0;
            m_lm = 1'b0; m_of = 1'b0; m_lf = 1'b0; m_pc = 0;
            return;
        end
        tk  = m_run && (m_pc == 11);
        cw  = b_wr && !b_borrow && (b_addr < 3'd2);
        rw  = b_wr && !b_borrow && (b_addr == 3'd2 || b_addr == 3'd3);
        ctw = b_wr && (b_addr == 3'd4);
        ov  = tk && !cw && (m_cnt == 16'hFFFF);
        lw  = tk && !cw && (m_cnt[7:0] == 8'hFF) && m_lm;
        m_pc = !m_run ? 0 : ((m_pc == 11) ? 0 : m_pc + 1);
        if (cw) begin
            if (b_addr == 3'd0) m_cnt[7:0] = b_wdata;
            else                m_cnt[15:8] = b_wdata;
        end else if (tk) begin
            m_cnt = (m_cnt == 16'hFFFF) ? m_rld : m_cnt + 16'd1;
        end
        if (rw) begin
            if (b_addr == 3'd2) m_rld[7:0] = b_wdata;
            else                m_rld[15:8] = b_wdata;
        end
        if (ov) m_of = 1'b1;
        else if (ctw && !b_wdata[7]) m_of = 1'b0;
        if (lw) m_lf = 1'b1;
        else if (ctw && !b_wdata[6]) m_lf = 1'b0;
        if (ctw) begin
            m_run = b_wdata[0]; m_ien = b_wdata[1]; m_lm = b_wdata[2];
        end
    endtask

    // one rising edge, then compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(rdata == exp_rd(b_addr),
            (b_addr < 3'd2) ? "R2 count read" : (b_addr == 3'd4) ? "R5 ctrl read" : "R9 map read",
            rdata, exp_rd(b_addr));
        chk(irq == exp_irq(), "R6 irq", irq, exp_irq());
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        cyc();
        b_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        b_addr = a;
        #1;
        chk(rdata == e, tag, rdata, e);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        #1;
        chk(irq == e, tag, irq, e);
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'h5eed_2402);
        cycn(3);
        rst = 1'b0;
        // R1 reset state
        rd_chk(0, 8'h00, "R1 cnt lo");
        rd_chk(1, 8'h00, "R1 cnt hi");
        rd_chk(2, 8'h00, "R1 rld lo");
        rd_chk(3, 8'h00, "R1 rld hi");
        rd_chk(4, 8'h01, "R1 ctrl");
        irq_chk(1'b0, "R1 irq");

        // R2 first tick exactly 12 edges after run set
        wr(4, 8'h00); wr(0, 8'h10); wr(1, 8'h00); wr(4, 8'h01);
        cycn(11); rd_chk(0, 8'h10, "R2 before tick");
        cyc();    rd_chk(0, 8'h11, "R2 on tick");

        // R3 overflow reload and flag, R6 irq
        wr(4, 8'h00); wr(2, 8'h34); wr(3, 8'h12); wr(0, 8'hFF); wr(1, 8'hFF);
        wr(4, 8'h03);
        cycn(11); rd_chk(1, 8'hFF, "R3 pre-overflow");
        cyc();
        rd_chk(0, 8'h34, "R3 reload lo");
        rd_chk(1, 8'h12, "R3 reload hi");
        rd_chk(4, 8'h83, "R3 ovf flag");
        irq_chk(1'b1, "R6 irq on ovf");

        // R5 sticky, clear by zero
        wr(4, 8'h83); rd_chk(4, 8'h83, "R5 write one keeps");
        wr(4, 8'h03); rd_chk(4, 8'h03, "R5 write zero clears");
        irq_chk(1'b0, "R6 irq after clear");

        // R4 low-byte wrap with and without mode
        wr(4, 8'h00); wr(0, 8'hFF); wr(1, 8'h00); wr(4, 8'h07);
        cycn(12);
        rd_chk(1, 8'h01, "R4 hi carry");
        rd_chk(4, 8'h47, "R4 lwrap flag");
        irq_chk(1'b1, "R4 irq on wrap");
        wr(4, 8'h00); wr(0, 8'hFF); wr(1, 8'h00); wr(4, 8'h03);
        cycn(12);
        rd_chk(4, 8'h03, "R4 no flag without mode");
        irq_chk(1'b0, "R4 no irq without mode");

        // R7 write on tick edge wins
        wr(4, 8'h00); wr(0, 8'h20); wr(1, 8'h00); wr(4, 8'h01);
        cycn(11); wr(0, 8'h77);
        rd_chk(0, 8'h77, "R7 write replaces step");
        cycn(12); rd_chk(0, 8'h78, "R7 next tick");

        // R8 borrow
        wr(4, 8'h00); wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'h03);
        cycn(12); irq_chk(1'b1, "R8 irq before borrow");
        b_borrow = 1'b1; irq_chk(1'b0, "R8 irq masked");
        wr(0, 8'h55); rd_chk(0, 8'h34, "R8 count write ignored");
        wr(2, 8'h99); rd_chk(2, 8'h34, "R8 reload write ignored");
        b_borrow = 1'b0; irq_chk(1'b1, "R8 irq returns");

        // R9 unused addresses
        wr(5, 8'hAB); rd_chk(5, 8'h00, "R9 addr5 reads zero");
        rd_chk(7, 8'h00, "R9 addr7 reads zero");
        rd_chk(2, 8'h34, "R9 reload untouched");

        // random traffic against the model
        for (int i = 0; i < 20000; i++) begin
            logic [2:0] a;
            r = $urandom;
            a = 3'($urandom % 6);
            b_addr  = a;
            b_wr    = (r % 9) == 0;
            b_wdata = 8'($urandom);
            if (a == 3'd1 || a == 3'd3) begin
                if (r[8]) b_wdata = 8'hFF;
            end
            if (a == 3'd4) begin
                b_wdata[5:3] = 3'b000;
                if (r[12:10] != 3'd0) b_wdata[0] = 1'b1;
            end
            if ((r >> 16) % 300 == 0) b_borrow = ~b_borrow;
            cyc();
        end
        b_wr = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule